// File: doc/BRIEF.md
# Triple-Modulus Frequency Divider

This block divides a fast input clock by 64, 65 or 72. Two select inputs choose the ratio. It is built the way a dual-modulus prescaler front end is built. A small front divider normally counts four input cycles. A 5-bit synchronous counter advances once each time the front divider completes. For the 65 ratio, the front divider counts five input cycles, but only in the final slot of each output period. For the 72 ratio, the front divider stays at four and the counter length grows from 16 to 18 slots.

The select inputs are captured once per output period, on the clock edge that ends the final count. The ratio in force therefore stays constant for the whole period. A change made mid-period applies to the next full period. Each period is counted from 1 up to its length N. The divided output is low from count N through count 31 of the next period, and high from count 32 up to count N-1. A terminal-count strobe marks count N. The captured ratio is visible as a 2-bit code.

All state is plain flip-flops advanced on the rising input edge, so the block works at any clock rate down to a stopped clock.

Top module: `tmd_divider`

## Requirements
- R1: While `rst_n` is low, the divider sits at count 1 with `div_out` high and `tc_pulse` low. The first rising edge after release moves it to count 2.
- R2: With `sel_b`=0 and `sel_a`=1, each period lasts 64 input cycles and `ratio_code` reads 2'b00.
- R3: With `sel_b`=0 and `sel_a`=0, each period lasts 65 input cycles and `ratio_code` reads 2'b01. The one extra cycle comes from the front divider counting five cycles in the final slot only.
- R4: With `sel_b`=1, each period lasts 72 input cycles whatever the value of `sel_a`, and `ratio_code` reads 2'b10.
- R5: In every period after the first, `div_out` is low at counts 1 to 31 and at count N, and high at counts 32 to N-1.
- R6: `tc_pulse` is high for exactly one input cycle per period: the cycle at count N.
- R7: `sel_a` and `sel_b` are sampled only on the edge that ends count N, and that sample sets the ratio of the following period. Values present at any other point of a period have no effect on that period's length or on `ratio_code`.
- R8: The first period after reset uses the select values present during count 1, and `ratio_code` shows them from count 2 on. In that period `div_out` stays high until it falls at count N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sel_a | input | 1 | Ratio select: with sel_b low, 1 gives 64 and 0 gives 65 |
| sel_b | input | 1 | Ratio select: 1 gives 72 |
| div_out | output | 1 | Divided output |
| ratio_code | output | 2 | Captured ratio: 00 = 64, 01 = 65, 10 = 72 |
| tc_pulse | output | 1 | High during the final count of each period |

## Verification
The bench builds the block with its default parameters: a front divider of four, base and long counter lengths of 16 and 18, and the output rising at count 32. These values make all three ratios reachable, together with the stretched five-cycle final slot. The bench runs sequences that switch 65 to 64, 65 to 72, 72 to 72 with the other select flipped, and back to 64 and 65. It also toggles the selects in the middle of every period, so any leak of a mid-period value shows up as a wrong period length or a wrong code. On every cycle the bench predicts the count position, `div_out`, `tc_pulse` and `ratio_code`.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

  typedef enum logic [1:0] {
    RATIO_BASE  = 2'b00,
    RATIO_PLUS1 = 2'b01,
    RATIO_LONG  = 2'b10
  } ratio_e;

  function automatic ratio_e pick_ratio(input logic sel_a, input logic sel_b);
    ratio_e r;
    if (sel_b)      r = RATIO_LONG;
    else if (sel_a) r = RATIO_BASE;
    else            r = RATIO_PLUS1;
    return r;
  endfunction

endpackage

// File: rtl/tmd_mode_latch.sv
module tmd_mode_latch
  import tmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_a,
  input  logic   sel_b,
  input  logic   period_end,
  output ratio_e eff_ratio,
  output ratio_e held_ratio
);

  logic   armed_q, armed_d;
  ratio_e ratio_q, ratio_d;
  logic   load_en;
  ratio_e live_ratio;

  always_comb begin
    live_ratio = pick_ratio(sel_a, sel_b);
    load_en    = !armed_q || period_end;
    ratio_d    = load_en ? live_ratio : ratio_q;
    armed_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ratio_q <= RATIO_BASE;
    end else begin
      armed_q <= armed_d;
      if (load_en) ratio_q <= ratio_d;
    end
  end

  assign eff_ratio  = armed_q ? ratio_q : live_ratio;
  assign held_ratio = ratio_q;

  // R7: the captured ratio never moves inside a period
  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !period_end) |=> $stable(ratio_q));

endmodule

// File: rtl/tmd_front.sv
module tmd_front #(
  parameter int PRE_DIV = 4,
  localparam int PW = $clog2(PRE_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stretch,
  output logic [PW-1:0] phase,
  output logic          slot_done
);

  logic [PW-1:0] phase_q, phase_d;
  logic [PW-1:0] top_val;

  always_comb begin
    top_val   = stretch ? PW'(PRE_DIV) : PW'(PRE_DIV - 1);
    slot_done = (phase_q == top_val);
    phase_d   = slot_done ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R3: the extra front-divider cycle exists only in a stretched slot
  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PW'(PRE_DIV));
  p_stretch_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PW'(PRE_DIV)) |-> stretch);

endmodule

// File: rtl/tmd_count.sv
module tmd_count #(
  parameter int BASE_LEN = 16,
  parameter int LONG_LEN = 18,
  localparam int CW = $clog2(LONG_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          long_mode,
  output logic [CW-1:0] idx,
  output logic          last
);

  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] last_val;

  always_comb begin
    last_val = long_mode ? CW'(LONG_LEN - 1) : CW'(BASE_LEN - 1);
    last     = (idx_q == last_val);
    idx_d    = last ? '0 : idx_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign idx = idx_q;

  // R4: the counter stays inside the long length and wraps at its end
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < CW'(LONG_LEN));
  p_idx_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last) |=> (idx_q == '0));

endmodule

// File: rtl/tmd_shaper.sv
module tmd_shaper
  import tmd_pkg::*;
#(
  parameter int PRE_DIV    = 4,
  parameter int BASE_LEN   = 16,
  parameter int LONG_LEN   = 18,
  parameter int HIGH_COUNT = 32,
  localparam int PW   = $clog2(PRE_DIV + 1),
  localparam int CW   = $clog2(LONG_LEN),
  localparam int POSW = $clog2(PRE_DIV * LONG_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] idx,
  input  logic [PW-1:0] phase,
  input  ratio_e        ratio,
  input  logic          period_end,
  output logic          div_out
);

  localparam int N_BASE = PRE_DIV * BASE_LEN;
  localparam int N_LONG = PRE_DIV * LONG_LEN;

  logic [POSW-1:0] pos0;
  logic [POSW-1:0] span;
  logic            out_q, out_d;

  always_comb begin
    pos0 = POSW'(idx) * POSW'(PRE_DIV) + POSW'(phase);
    case (ratio)
      RATIO_PLUS1: span = POSW'(N_BASE + 1);
      RATIO_LONG:  span = POSW'(N_LONG);
      default:     span = POSW'(N_BASE);
    endcase
    if (pos0 == span - POSW'(2))            out_d = 1'b0;
    else if (pos0 == POSW'(HIGH_COUNT - 2)) out_d = 1'b1;
    else                                    out_d = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= out_d;
  end

  assign div_out = out_q;

  // R5: the output falls only on the final count and rises only on the high count
  p_fall_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> period_end);
  p_rise_at_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (pos0 == POSW'(HIGH_COUNT - 1)));

endmodule

// File: rtl/tmd_divider.sv
module tmd_divider
  import tmd_pkg::*;
#(
  parameter int PRE_DIV    = 4,
  parameter int BASE_LEN   = 16,
  parameter int LONG_LEN   = 18,
  parameter int HIGH_COUNT = 32
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       sel_a,
  input  logic       sel_b,
  output logic       div_out,
  output logic [1:0] ratio_code,
  output logic       tc_pulse
);

  localparam int PW   = $clog2(PRE_DIV + 1);
  localparam int CW   = $clog2(LONG_LEN);
  localparam int POSW = $clog2(PRE_DIV * LONG_LEN + 1);

  ratio_e        eff_ratio, held_ratio;
  logic [PW-1:0] phase;
  logic          slot_done;
  logic [CW-1:0] idx;
  logic          last;
  logic          stretch, long_mode, period_end;

  assign stretch    = (eff_ratio == RATIO_PLUS1) && last;
  assign long_mode  = (eff_ratio == RATIO_LONG);
  assign period_end = slot_done && last;

  tmd_mode_latch i_mode (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .period_end (period_end),
    .eff_ratio  (eff_ratio),
    .held_ratio (held_ratio)
  );

  tmd_front #(.PRE_DIV(PRE_DIV)) i_front (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .stretch   (stretch),
    .phase     (phase),
    .slot_done (slot_done)
  );

  tmd_count #(.BASE_LEN(BASE_LEN), .LONG_LEN(LONG_LEN)) i_count (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .advance   (slot_done),
    .long_mode (long_mode),
    .idx       (idx),
    .last      (last)
  );

  tmd_shaper #(
    .PRE_DIV    (PRE_DIV),
    .BASE_LEN   (BASE_LEN),
    .LONG_LEN   (LONG_LEN),
    .HIGH_COUNT (HIGH_COUNT)
  ) i_shape (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .idx        (idx),
    .phase      (phase),
    .ratio      (eff_ratio),
    .period_end (period_end),
    .div_out    (div_out)
  );

  assign ratio_code = held_ratio;
  assign tc_pulse   = period_end;

  // Period-length watch counter, used by the assertions only
  logic [POSW-1:0] chk_cyc;
  logic [POSW-1:0] chk_span;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)        chk_cyc <= '0;
    else if (tc_pulse) chk_cyc <= '0;
    else               chk_cyc <= chk_cyc + POSW'(1);
  end

  always_comb begin
    case (held_ratio)
      RATIO_PLUS1: chk_span = POSW'(PRE_DIV * BASE_LEN + 1);
      RATIO_LONG:  chk_span = POSW'(PRE_DIV * LONG_LEN);
      default:     chk_span = POSW'(PRE_DIV * BASE_LEN);
    endcase
  end

  // R6: the strobe lasts one cycle
  p_tc_single_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);
  // R2: the period length matches the captured ratio
  p_period_len_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    tc_pulse |-> (chk_cyc == chk_span - POSW'(1)));

endmodule

// File: tb/test_tmd_divider.sv
module test_tmd_divider;

  localparam int CLK_PERIOD = 10;
  localparam int HIGH_AT    = 32;

  logic       clk;
  logic       rst_n;
  logic       sel_a, sel_b;
  logic       div_out;
  logic [1:0] ratio_code;
  logic       tc_pulse;

  int         checks;
  int         errors;
  bit         mon_go;
  int         q_len[$];
  logic [1:0] q_code[$];

  tmd_divider i_tmd_divider (
    .clk_in     (clk),
    .rst_n      (rst_n),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .div_out    (div_out),
    .ratio_code (ratio_code),
    .tc_pulse   (tc_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input logic [1:0] code);
    if (code == 2'b01)      return "R3";
    else if (code == 2'b10) return "R4";
    return "R2";
  endfunction

  // Driver: sets the selects during the final count of the running period
  // (so R7 samples them) and then writes junk values mid-period.
  task automatic queue_period(input logic a, input logic b, input int len,
                              input logic [1:0] code, input logic ja, input logic jb);
    do @(negedge clk); while (tc_pulse !== 1'b1);
    sel_a = a;
    sel_b = b;
    q_len.push_back(len);
    q_code.push_back(code);
    @(negedge clk);
    sel_a = ja;
    sel_b = jb;
  endtask

  // Monitor: scoreboard pop at each period start, per-cycle comparison
  int         cnt;
  bit         first;
  bit         active;
  int         cur_len;
  logic [1:0] cur_code;
  logic       exp_out;

  initial begin
    cnt = 0; first = 1'b1; active = 1'b0; cur_len = 0; cur_code = 2'b00;
    wait (mon_go);
    forever begin
      #1;
      cnt++;
      if (cnt == 1) begin
        if (q_len.size() == 0) active = 1'b0;
        else begin
          cur_len  = q_len.pop_front();
          cur_code = q_code.pop_front();
          active   = 1'b1;
        end
      end
      if (active) begin
        if (first) begin
          exp_out = (cnt != cur_len);
          check(div_out === exp_out, "R8 first-period output", div_out, exp_out);
        end else begin
          exp_out = (cnt >= HIGH_AT) && (cnt < cur_len);
          check(div_out === exp_out, "R5 output shape", div_out, exp_out);
        end
        check(tc_pulse === (cnt == cur_len), "R6 strobe position", tc_pulse, cnt == cur_len);
        if (tc_pulse === 1'b1)
          check(cnt == cur_len, {req_of(cur_code), " R7 period length"}, cnt, cur_len);
        if (!(first && cnt == 1))
          check(ratio_code === cur_code, {req_of(cur_code), " R7 ratio code"}, ratio_code, cur_code);
      end
      if (tc_pulse === 1'b1) begin
        cnt   = 0;
        first = 1'b0;
      end
      @(negedge clk);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; mon_go = 1'b0;
    rst_n = 1'b0; sel_a = 1'b1; sel_b = 1'b0;
    q_len.push_back(64);
    q_code.push_back(2'b00);
    repeat (3) @(negedge clk);
    #1;
    check(div_out === 1'b1, "R1 reset output", div_out, 1);
    check(tc_pulse === 1'b0, "R1 reset strobe", tc_pulse, 0);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_go = 1'b1;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b1;                    // junk after count 1 (R8)
    queue_period(1'b0, 1'b0, 65, 2'b01, 1'b1, 1'b1);
    queue_period(1'b1, 1'b0, 64, 2'b00, 1'b0, 1'b1);  // 65 -> 64
    queue_period(1'b0, 1'b0, 65, 2'b01, 1'b1, 1'b0);
    queue_period(1'b1, 1'b1, 72, 2'b10, 1'b0, 1'b0);  // 65 -> 72
    queue_period(1'b0, 1'b1, 72, 2'b10, 1'b1, 1'b0);  // 72, other select flipped
    queue_period(1'b1, 1'b0, 64, 2'b00, 1'b0, 1'b0);
    queue_period(1'b1, 1'b1, 72, 2'b10, 1'b0, 1'b0);
    queue_period(1'b0, 1'b0, 65, 2'b01, 1'b0, 1'b1);
    queue_period(1'b0, 1'b0, 65, 2'b01, 1'b1, 1'b1);
    wait (q_len.size() == 0);
    do @(negedge clk); while (tc_pulse !== 1'b1);
    #2;
    finish_run();
  end

endmodule